// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a serial port that moves bytes only in synchronous shift-register fashion. The port drives its own shift clock, derived from the system (oscillator) clock at one bit per twelve clock cycles. It uses a single data line in both directions. For transmission the port drives the line. For reception it releases the line and samples it. The data pin is split into `dataIn`, `dataOut` and a drive enable, so that a pad cell outside the block can combine them.

Software reaches the port through a two-entry register interface. Address 0 is the control register. It holds the receive-enable bit, the transmit-complete flag, the receive-complete flag and five general bits. Address 1 is the data buffer. A write to it loads a byte for transmission, and a read returns the last byte received. A buffer write starts a transmission. A control write that leaves reception enabled and the receive flag clear starts a reception. The two flags are wired out of the register bits to the interrupt logic.

Top module: `ssp_top`

## Requirements
- R1: After reset the control register and the receive buffer read as 00h, the shift clock is high, `dataOutEn` is low and `dataOut` is 1.
- R2: During a transfer each bit occupies 12 clock cycles. The shift clock is high for cycles 0-3 of the bit, low for cycles 4-9 and high again for cycles 10-11. Its rising edge therefore comes 10 cycles after the bit starts, and the bit is held 2 cycles after that edge. With no transfer in progress the shift clock stays high.
- R3: A write to address 1 while idle starts a transmission. From the cycle after the write, `dataOutEn` is high for 96 cycles and `dataOut` presents bits 0 to 7 of the written byte, least significant first, each for 12 cycles.
- R4: At the end of the 96th cycle of a transmission, control bit 1 (transmit complete) becomes 1, and `dataOutEn` goes low with `dataOut` returning to 1.
- R5: A write to address 0 while idle, with bit 4 (receive enable) at 1 and bit 0 (receive complete) at 0, starts a 96-cycle reception. `dataOutEn` stays low throughout. Any other control write starts nothing.
- R6: During a reception `dataIn` is sampled at each rising edge of the shift clock, and the first sample becomes bit 0. After the eighth sample, control bit 0 becomes 1 and address 1 reads the assembled byte.
- R7: Control bits 1 and 0 are loaded by software writes to address 0, which can clear or set them. Hardware only ever sets them. When hardware sets a flag in the same cycle as a software write to the control register, the flag ends up at 1.
- R8: While a transfer is in progress, a write to address 1 and a receive-start control write start nothing. The transfer in progress runs to its end unchanged, and the shift clock stays high afterwards.
- R9: Control bits 7 to 2 read back exactly as written. Of these, only bit 4 affects the port, and only through the start condition of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 data buffer |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| shiftClk | output | 1 | Shift clock, idles high |
| dataIn | input | 1 | Serial line as seen by the receiver |
| dataOut | output | 1 | Serial line value driven during transmission |
| dataOutEn | output | 1 | Drive enable for the serial line |
| txDoneFlag | output | 1 | Transmit-complete flag (control bit 1) |
| rxDoneFlag | output | 1 | Receive-complete flag (control bit 0) |

## Verification
The collision that matters here is a software write to the control register that lands on the same clock edge at which the shifter finishes a byte and sets a flag. The write tries to clear the flag, and could also try to re-arm reception. The bench counts cycles from the starting write and places a clearing control write exactly on the 96th edge, once after a transmission and once after a reception. A behavioural model then judges the result: the flag must read 1 and no new transfer may begin. The model also compares shift clock, line and read data on every cycle.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

  // Strobes from the sequencer to the datapath, one cycle wide except txActive.
  typedef struct packed {
    logic loadTx;    // capture write data into the shifter, begin sending
    logic armRx;     // clear the shifter, begin receiving
    logic sampleIn;  // take one input bit (edge where shift clock rises)
    logic shiftOut;  // advance to the next output bit
    logic doneTx;    // last output bit finished
    logic doneRx;    // last input bit finished
    logic txActive;  // a transmission owns the line
  } sspStrobes_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TX   = 2'd1,
    SEQ_RX   = 2'd2
  } sspSeq_t;

endpackage

// File: rtl/ssp_ctrl.sv
`timescale 1ns/1ps
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_PERIOD = 12,
  parameter int HOLD_CYC   = 2,
  parameter int LOW_CYC    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrCtrl,
  input  logic        wrBuf,
  input  logic        renWr,
  input  logic        riWr,
  output sspStrobes_t strb,
  output logic        shiftClk
);

  localparam int PH_W    = $clog2(BIT_PERIOD);
  localparam int CNT_W   = $clog2(DATA_W);
  localparam int RISE_PH = BIT_PERIOD - HOLD_CYC;
  localparam int FALL_PH = RISE_PH - LOW_CYC;
  localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(BIT_PERIOD - 1);
  localparam logic [PH_W-1:0]  SAMPLE_PH = PH_W'(RISE_PH - 1);
  localparam logic [PH_W-1:0]  LOW_FROM  = PH_W'(FALL_PH);
  localparam logic [PH_W-1:0]  LOW_UNTIL = PH_W'(RISE_PH);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);

  sspSeq_t          seq;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] bitIdx;
  logic             idle;
  logic             lastSlot;
  logic             lastBit;

  assign idle     = (seq == SEQ_IDLE);
  assign lastSlot = (phase == LAST_PH);
  assign lastBit  = (bitIdx == LAST_BIT);

  always_comb begin
    strb          = '0;
    strb.loadTx   = idle && wrBuf;
    strb.armRx    = idle && wrCtrl && renWr && !riWr;
    strb.txActive = (seq == SEQ_TX);
    strb.sampleIn = (seq == SEQ_RX) && (phase == SAMPLE_PH);
    strb.shiftOut = (seq == SEQ_TX) && lastSlot && !lastBit;
    strb.doneTx   = (seq == SEQ_TX) && lastSlot && lastBit;
    strb.doneRx   = (seq == SEQ_RX) && lastSlot && lastBit;
  end

  // Low window of the shift clock inside each bit slot.
  assign shiftClk = !(!idle && (phase >= LOW_FROM) && (phase < LOW_UNTIL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq    <= SEQ_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (idle) begin
      phase  <= '0;
      bitIdx <= '0;
      if (strb.loadTx)     seq <= SEQ_TX;
      else if (strb.armRx) seq <= SEQ_RX;
    end else if (lastSlot) begin
      phase <= '0;
      if (lastBit) begin
        seq    <= SEQ_IDLE;
        bitIdx <= '0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/ssp_dp.sv
`timescale 1ns/1ps
module ssp_dp
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TI_BIT = 1,
  parameter int RI_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sspStrobes_t       strb,
  input  logic              wrCtrl,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              tiFlag,
  output logic              riFlag
);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rxBuf;
  logic [DATA_W-1:0] ctrlReg;

  // Shifter: loads for sending, clears for receiving, moves LSB first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg <= '0;
    end else if (strb.loadTx) begin
      shReg <= wrData;
    end else if (strb.armRx) begin
      shReg <= '0;
    end else if (strb.sampleIn) begin
      shReg <= {dataIn, shReg[DATA_W-1:1]};
    end else if (strb.shiftOut) begin
      shReg <= {1'b1, shReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rxBuf <= '0;
    else if (strb.doneRx) rxBuf <= shReg;
  end

  // Control register: software loads all bits; hardware sets after the
  // write so a completing transfer always leaves its flag raised.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
    end else begin
      if (wrCtrl)      ctrlReg         <= wrData;
      if (strb.doneTx) ctrlReg[TI_BIT] <= 1'b1;
      if (strb.doneRx) ctrlReg[RI_BIT] <= 1'b1;
    end
  end

  assign tiFlag    = ctrlReg[TI_BIT];
  assign riFlag    = ctrlReg[RI_BIT];
  assign dataOutEn = strb.txActive;
  assign dataOut   = strb.txActive ? shReg[0] : 1'b1;
  assign rdData    = regAddr ? rxBuf : ctrlReg;

endmodule

// File: rtl/ssp_top.sv
`timescale 1ns/1ps
module ssp_top
  import ssp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_PERIOD = 12,
  parameter int HOLD_CYC   = 2,
  parameter int LOW_CYC    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              shiftClk,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn,
  output logic              txDoneFlag,
  output logic              rxDoneFlag
);

  localparam int REN_BIT = 4;
  localparam int TI_BIT  = 1;
  localparam int RI_BIT  = 0;

  sspStrobes_t strb;
  logic        wrCtrl;
  logic        wrBuf;

  assign wrCtrl = regWrEn && !regAddr;
  assign wrBuf  = regWrEn &&  regAddr;

  ssp_ctrl #(
    .DATA_W(DATA_W), .BIT_PERIOD(BIT_PERIOD),
    .HOLD_CYC(HOLD_CYC), .LOW_CYC(LOW_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrCtrl   (wrCtrl),
    .wrBuf    (wrBuf),
    .renWr    (regWrData[REN_BIT]),
    .riWr     (regWrData[RI_BIT]),
    .strb     (strb),
    .shiftClk (shiftClk)
  );

  ssp_dp #(
    .DATA_W(DATA_W), .TI_BIT(TI_BIT), .RI_BIT(RI_BIT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wrCtrl    (wrCtrl),
    .regAddr   (regAddr),
    .wrData    (regWrData),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn),
    .rdData    (regRdData),
    .tiFlag    (txDoneFlag),
    .riFlag    (rxDoneFlag)
  );

endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker #(
  parameter int LOW_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic shiftClk,
  input logic dataOut,
  input logic dataOutEn,
  input logic wrCtrl,
  input logic tiFlag,
  input logic riFlag,
  input logic loadTx,
  input logic armRx,
  input logic doneTx,
  input logic doneRx
);

  logic [7:0] lowRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowRun <= '0;
    else if (shiftClk) lowRun <= '0;
    else if (lowRun != 8'hFF) lowRun <= lowRun + 1'b1;
  end

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shiftClk) |-> (lowRun == 8'(LOW_CYC))); // R2

  AST_DATA_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dataOutEn && $past(dataOutEn) && !shiftClk) |-> $stable(dataOut)); // R2

  AST_TX_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    doneTx |=> tiFlag); // R4

  AST_RX_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    doneRx |=> riFlag); // R6

  AST_TI_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tiFlag) |-> $past(wrCtrl)); // R7

  AST_RI_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(riFlag) |-> $past(wrCtrl)); // R7

  AST_START_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (loadTx || armRx) |-> (shiftClk && !dataOutEn)); // R8

endmodule

bind ssp_top ssp_checker #(.LOW_CYC(LOW_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shiftClk  (shiftClk),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn),
  .wrCtrl    (wrCtrl),
  .tiFlag    (txDoneFlag),
  .riFlag    (rxDoneFlag),
  .loadTx    (strb.loadTx),
  .armRx     (strb.armRx),
  .doneTx    (strb.doneTx),
  .doneRx    (strb.doneRx)
);

// File: tb/sim_ssp_top.sv
`timescale 1ns/1ps
module sim_ssp_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       shiftClk;
  logic       dataIn;
  logic       dataOut;
  logic       dataOutEn;
  logic       txDoneFlag;
  logic       rxDoneFlag;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  ssp_top u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .shiftClk(shiftClk),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .txDoneFlag(txDoneFlag), .rxDoneFlag(rxDoneFlag)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- external device driving the line during receive
  logic [7:0] rxPattern = 8'h00;
  int         rxIdx = 0;
  logic       prevSclk = 1'b1;
  assign dataIn = rxPattern[rxIdx % 8];

  always @(negedge clk) begin
    if (shiftClk && !prevSclk) rxIdx <= rxIdx + 1;
    prevSclk <= shiftClk;
  end

  // ---------------- behavioural reference
  bit         mBusy, mTx, wasBusy;
  int         mCyc;
  logic [7:0] mCtrl, mRxBuf, mSh, mTxByte;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mBusy = 0; mTx = 0; mCyc = 0;
      mCtrl = 8'h00; mRxBuf = 8'h00; mSh = 8'h00; mTxByte = 8'h00;
    end else begin
      wasBusy = mBusy;
      if (regWrEn && !regAddr) mCtrl = regWrData;
      if (wasBusy) begin
        if (mCyc == 95) begin
          mBusy = 0;
          if (mTx) mCtrl[1] = 1'b1;
          else begin mCtrl[0] = 1'b1; mRxBuf = mSh; end
        end else begin
          if (!mTx && (mCyc % 12) == 9) mSh = {dataIn, mSh[7:1]};
          mCyc++;
        end
      end else if (regWrEn && regAddr) begin
        mBusy = 1; mTx = 1; mCyc = 0; mTxByte = regWrData;
      end else if (regWrEn && !regAddr && regWrData[4] && !regWrData[0]) begin
        mBusy = 1; mTx = 0; mCyc = 0; mSh = 8'h00;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 shift clock", shiftClk,
          !(mBusy && (mCyc % 12) >= 4 && (mCyc % 12) < 10));
      chk("R3 drive enable", dataOutEn, mBusy && mTx);
      chk("R3 line value", dataOut, (mBusy && mTx) ? mTxByte[mCyc / 12] : 1'b1);
      chk("R7 register read", regRdData, regAddr ? mRxBuf : mCtrl);
      chk("R4 transmit flag pin", txDoneFlag, mCtrl[1]);
      chk("R6 receive flag pin", rxDoneFlag, mCtrl[0]);
    end
  end

  // ---------------- stimulus helpers (drive 3 ns after the edge)
  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("WATCHDOG expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 control after reset", regRdData, 8'h00);
    chk("R1 shift clock idle high", shiftClk, 1'b1);
    chk("R1 line released", dataOutEn, 1'b0);
    chk("R1 line idle value", dataOut, 1'b1);
    regAddr = 1'b1; #1;
    chk("R1 buffer after reset", regRdData, 8'h00);
    regAddr = 1'b0;

    // R3/R4 transmit with a buffer write in mid-flight (R8)
    wrReg(1'b1, 8'hA5);
    repeat (40) tick();
    wrReg(1'b1, 8'h3C);
    repeat (70) tick();
    chk("R4 transmit flag set", regRdData, 8'h02);
    chk("R8 no second transfer", dataOutEn, 1'b0);
    chk("R8 shift clock stays high", shiftClk, 1'b1);

    wrReg(1'b0, 8'h00);
    chk("R7 software clears flag", regRdData, 8'h00);

    // R7 collision: clearing write on the completing edge
    wrReg(1'b1, 8'h5A);
    repeat (95) tick();
    wrReg(1'b0, 8'h00);
    tick();
    chk("R7 hardware set wins on transmit", regRdData[1], 1'b1);

    // R5/R6 receive
    rxPattern = 8'hC3; rxIdx = 0;
    wrReg(1'b0, 8'h10);
    repeat (110) tick();
    chk("R6 receive flag set", regRdData, 8'h11);
    regAddr = 1'b1; #1;
    chk("R6 received byte", regRdData, 8'hC3);
    regAddr = 1'b0;

    // R5 no start when flag still set; R9 upper bits stored
    wrReg(1'b0, 8'hFF);
    repeat (30) tick();
    chk("R9 readback all ones", regRdData, 8'hFF);
    chk("R5 no reception with flag set", shiftClk, 1'b1);
    wrReg(1'b0, 8'hEC);
    repeat (30) tick();
    chk("R9 readback pattern", regRdData, 8'hEC);
    chk("R5 no reception without enable", shiftClk, 1'b1);

    // R6/R7/R8 receive with restart attempt and collision at the end
    wrReg(1'b0, 8'h00);
    rxPattern = 8'h96; rxIdx = 0;
    wrReg(1'b0, 8'h10);
    repeat (40) tick();
    wrReg(1'b0, 8'h10);
    repeat (54) tick();
    wrReg(1'b0, 8'h10);
    tick();
    chk("R7 hardware set wins on receive", regRdData, 8'h11);
    regAddr = 1'b1; #1;
    chk("R6 second received byte", regRdData, 8'h96);
    regAddr = 1'b0;
    repeat (20) tick();
    chk("R8 no restart after collision", shiftClk, 1'b1);

    // R3 another pattern; R7 software can set flags
    wrReg(1'b1, 8'h01);
    repeat (100) tick();
    wrReg(1'b0, 8'h03);
    chk("R7 software sets flags", regRdData, 8'h03);
    repeat (5) tick();

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule